// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block keeps a set of hardware packet queues. Each queue is a singly linked list of descriptor indices. All queues share one link store, which holds one entry per global descriptor number. Software places a descriptor on a queue by presenting the descriptor's address with a push strobe and the queue number. It takes the head descriptor off a queue by raising a pop strobe. On the next cycle the block returns that head descriptor's address. A separate peek port reports the head address and the entry count of any queue without changing it. The block also drives one non-empty status bit per queue and an interrupt line for each queue that is built as interruptible.

Descriptor addresses are turned into link indices through a region table fixed by parameters. Each region has a base address, a descriptor count, a descriptor size (a power of two) and the index of its first descriptor. An address that matches no region, or that is not aligned to its region's descriptor size, is dropped and sets a sticky error flag. On a pop the index is translated back to an address.

Each cycle the controller decodes one of four operation kinds from the strobes:
- idle: no push and no pop.
- push only.
- pop only.
- push and pop together.

In the push-and-pop case, when both strobes name the same queue, the push takes effect before the pop.

Top module: `desc_qmgr`

## Requirements
- R1: After reset every queue is empty. `q_nonempty`, `irq`, `bad_push_err`, `pop_valid` and `pop_addr` are all zero.
- R2: A pop in cycle N raises `pop_valid` in cycle N+1. `pop_addr` in that cycle holds the address of the head descriptor removed from the queue, and the queue count drops by one.
- R3: Each queue returns its descriptors in push order. Operations on one queue leave the order and counts of other queues unchanged.
- R4: The peek port reports the head descriptor address and the count of `peek_q`, and peeking changes no queue. `peek_addr` is zero when the queue is empty.
- R5: A pop of an empty queue returns `pop_addr` = 0 and leaves that queue empty.
- R6: A pushed address outside every region is dropped. The target queue is unchanged and `bad_push_err` becomes 1 and stays 1 until reset.
- R7: A pushed address inside a region but not a multiple of that region's descriptor size from its base is dropped, with the same effect as in R6.
- R8: With the default regions, the translation is as follows. Region 0 has base 0x1000, 16 descriptors of 64 bytes and start index 0. Region 1 has base 0x8000, 16 descriptors of 128 bytes and start index 16. Address base+k·size maps to index start+k. The last descriptor of each region (0x13C0 and 0x8780) is accepted, and the addresses 0x1400 and 0x8800, one descriptor past each region's end, are rejected.
- R9: A push and a pop to the same queue in one cycle are applied push first, so the queue count is unchanged. On an empty queue the pop returns the pushed address. On a queue holding one entry, the pop returns the old head, and the pushed descriptor becomes both head and tail.
- R10: `q_nonempty[q]` is 1 exactly when queue q holds at least one descriptor. It is updated in the cycle after the operation.
- R11: `irq[q]` equals `q_nonempty[q]` for interruptible queues and is 0 for all others. The default interruptible set is queues 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Push strobe, one descriptor per cycle |
| push_q | input | QW | Target queue of the push |
| push_addr | input | AW | Descriptor address being pushed |
| pop_en | input | 1 | Pop strobe |
| pop_q | input | QW | Queue to pop |
| pop_valid | output | 1 | Pop result valid, one cycle after `pop_en` |
| pop_addr | output | AW | Popped descriptor address, 0 if the queue was empty |
| peek_q | input | QW | Queue selected for peek |
| peek_addr | output | AW | Head address of `peek_q`, 0 if empty |
| peek_count | output | CW | Entry count of `peek_q` |
| q_nonempty | output | NUM_Q | Per-queue non-empty status |
| irq | output | NUM_Q | Non-empty interrupt, interruptible queues only |
| bad_push_err | output | 1 | Sticky dropped-push flag |

## Verification
The bench first builds interleaved lists on several queues with descriptors from both regions. The main corner case is a same-cycle push and pop on a queue holding exactly one entry. If the design read the stale link entry, the next pop would return a wrong or zero address. A design that ordered the pop ahead of the push would fail on an empty queue, returning zero instead of the pushed address. The bench also pushes the last descriptor of each region and addresses one descriptor past each end. An off-by-one bound would either drop a good descriptor or queue a bad one. The bench checks a misaligned push, a pop of an empty queue and repeated peeks through the count and head at the ports, so a design that altered state on any of these would show a changed count. The status and interrupt vectors are compared together to catch an interrupt raised on a queue outside the interruptible set.

// File: rtl/desc_qmgr_pkg.sv
package desc_qmgr_pkg;
    // Operation kind decoded each cycle from the two bus strobes
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_BOTH = 2'd3
    } op_e;
endpackage

// File: rtl/desc_link_ram.sv
module desc_link_ram #(
    parameter int NUM_DESC = 32,
    localparam int IW = $clog2(NUM_DESC)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [IW-1:0] rdata
);
    logic [IW-1:0] mem [NUM_DESC];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/desc_fwd_xlate.sv
module desc_fwd_xlate #(
    parameter int NUM_DESC = 32,
    parameter int NUM_REG  = 2,
    parameter int AW       = 32,
    parameter logic [NUM_REG-1:0][AW-1:0] REG_BASE  = {32'h0000_8000, 32'h0000_1000},
    parameter logic [NUM_REG-1:0][AW-1:0] REG_CNT   = {32'd16, 32'd16},
    parameter logic [NUM_REG-1:0][4:0]    REG_SZLOG = {5'd7, 5'd6},
    parameter logic [NUM_REG-1:0][AW-1:0] REG_START = {32'd16, 32'd0},
    localparam int IW = $clog2(NUM_DESC)
) (
    input  logic [AW-1:0] addr_i,
    output logic          ok_o,
    output logic [IW-1:0] idx_o
);
    logic [NUM_REG-1:0] hit;
    logic [IW-1:0]      idx_r [NUM_REG];

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        localparam logic [AW-1:0] ALIGN_MASK = (AW'(1) << REG_SZLOG[r]) - AW'(1);
        logic [AW-1:0] off;
        assign off      = addr_i - REG_BASE[r];
        assign hit[r]   = (addr_i >= REG_BASE[r])
                       && ((off >> REG_SZLOG[r]) < REG_CNT[r])
                       && ((off & ALIGN_MASK) == '0);
        assign idx_r[r] = IW'(REG_START[r] + (off >> REG_SZLOG[r]));
    end

    // lowest-numbered matching region wins
    always_comb begin
        ok_o  = 1'b0;
        idx_o = '0;
        for (int r = NUM_REG - 1; r >= 0; r--) begin
            if (hit[r]) begin
                ok_o  = 1'b1;
                idx_o = idx_r[r];
            end
        end
    end
endmodule

// File: rtl/desc_rev_xlate.sv
module desc_rev_xlate #(
    parameter int NUM_DESC = 32,
    parameter int NUM_REG  = 2,
    parameter int AW       = 32,
    parameter logic [NUM_REG-1:0][AW-1:0] REG_BASE  = {32'h0000_8000, 32'h0000_1000},
    parameter logic [NUM_REG-1:0][AW-1:0] REG_CNT   = {32'd16, 32'd16},
    parameter logic [NUM_REG-1:0][4:0]    REG_SZLOG = {5'd7, 5'd6},
    parameter logic [NUM_REG-1:0][AW-1:0] REG_START = {32'd16, 32'd0},
    localparam int IW = $clog2(NUM_DESC)
) (
    input  logic [IW-1:0] idx_i,
    output logic [AW-1:0] addr_o
);
    logic [NUM_REG-1:0] hit;
    logic [AW-1:0]      addr_r [NUM_REG];

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        logic [AW-1:0] rel;
        assign rel       = AW'(idx_i) - REG_START[r];
        assign hit[r]    = (AW'(idx_i) >= REG_START[r]) && (rel < REG_CNT[r]);
        assign addr_r[r] = REG_BASE[r] + (rel << REG_SZLOG[r]);
    end

    always_comb begin
        addr_o = '0;
        for (int r = NUM_REG - 1; r >= 0; r--) begin
            if (hit[r]) begin
                addr_o = addr_r[r];
            end
        end
    end
endmodule

// File: rtl/desc_qmgr.sv
module desc_qmgr
    import desc_qmgr_pkg::*;
#(
    parameter int NUM_Q    = 8,
    parameter int NUM_DESC = 32,
    parameter int NUM_REG  = 2,
    parameter int AW       = 32,
    parameter logic [NUM_REG-1:0][AW-1:0] REG_BASE  = {32'h0000_8000, 32'h0000_1000},
    parameter logic [NUM_REG-1:0][AW-1:0] REG_CNT   = {32'd16, 32'd16},
    parameter logic [NUM_REG-1:0][4:0]    REG_SZLOG = {5'd7, 5'd6},
    parameter logic [NUM_REG-1:0][AW-1:0] REG_START = {32'd16, 32'd0},
    parameter logic [NUM_Q-1:0]           IRQ_MASK  = 8'hF0,
    localparam int QW = $clog2(NUM_Q),
    localparam int IW = $clog2(NUM_DESC),
    localparam int CW = $clog2(NUM_DESC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [QW-1:0]    push_q,
    input  logic [AW-1:0]    push_addr,
    input  logic             pop_en,
    input  logic [QW-1:0]    pop_q,
    output logic             pop_valid,
    output logic [AW-1:0]    pop_addr,
    input  logic [QW-1:0]    peek_q,
    output logic [AW-1:0]    peek_addr,
    output logic [CW-1:0]    peek_count,
    output logic [NUM_Q-1:0] q_nonempty,
    output logic [NUM_Q-1:0] irq,
    output logic             bad_push_err
);
    // per-queue list state
    logic [IW-1:0] head_q [NUM_Q];
    logic [IW-1:0] tail_q [NUM_Q];
    logic [CW-1:0] cnt_q  [NUM_Q];

    logic          xl_ok;
    logic [IW-1:0] push_idx;
    logic          push_ok;
    logic          same_q;
    op_e           op;

    logic [CW-1:0] pop_cnt_cur;
    logic [IW-1:0] pop_head;
    logic [IW-1:0] link_next;
    logic          pop_has;
    logic [IW-1:0] pop_src_idx;
    logic [AW-1:0] pop_src_addr;
    logic [AW-1:0] peek_head_addr;

    logic          link_we;

    desc_fwd_xlate #(
        .NUM_DESC(NUM_DESC), .NUM_REG(NUM_REG), .AW(AW),
        .REG_BASE(REG_BASE), .REG_CNT(REG_CNT),
        .REG_SZLOG(REG_SZLOG), .REG_START(REG_START)
    ) u_fwd (
        .addr_i (push_addr),
        .ok_o   (xl_ok),
        .idx_o  (push_idx)
    );

    assign push_ok     = push_en && xl_ok;
    assign same_q      = push_ok && pop_en && (push_q == pop_q);
    assign pop_cnt_cur = cnt_q[pop_q];
    assign pop_head    = head_q[pop_q];

    // operation decode
    always_comb begin
        unique case ({push_ok, pop_en})
            2'b00:   op = OP_IDLE;
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            default: op = OP_BOTH;
        endcase
    end

    // new descriptor links behind the current tail of a non-empty queue
    assign link_we = push_ok && (cnt_q[push_q] != '0);

    desc_link_ram #(.NUM_DESC(NUM_DESC)) u_link (
        .clk   (clk),
        .we    (link_we),
        .waddr (tail_q[push_q]),
        .wdata (push_idx),
        .raddr (pop_head),
        .rdata (link_next)
    );

    // pop source: stored head, or the descriptor pushed this cycle onto an empty queue
    assign pop_has     = (pop_cnt_cur != '0) || same_q;
    assign pop_src_idx = (pop_cnt_cur != '0) ? pop_head : push_idx;

    desc_rev_xlate #(
        .NUM_DESC(NUM_DESC), .NUM_REG(NUM_REG), .AW(AW),
        .REG_BASE(REG_BASE), .REG_CNT(REG_CNT),
        .REG_SZLOG(REG_SZLOG), .REG_START(REG_START)
    ) u_rev_pop (
        .idx_i  (pop_src_idx),
        .addr_o (pop_src_addr)
    );

    desc_rev_xlate #(
        .NUM_DESC(NUM_DESC), .NUM_REG(NUM_REG), .AW(AW),
        .REG_BASE(REG_BASE), .REG_CNT(REG_CNT),
        .REG_SZLOG(REG_SZLOG), .REG_START(REG_START)
    ) u_rev_peek (
        .idx_i  (head_q[peek_q]),
        .addr_o (peek_head_addr)
    );

    // queue state registers
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic push_here;
        logic pop_here;
        assign push_here = push_ok && (push_q == QW'(q));
        assign pop_here  = pop_en && (pop_q == QW'(q));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                head_q[q] <= '0;
                tail_q[q] <= '0;
                cnt_q[q]  <= '0;
            end else begin
                unique case ({push_here, pop_here})
                    2'b10: begin
                        if (cnt_q[q] == '0) begin
                            head_q[q] <= push_idx;
                        end
                        tail_q[q] <= push_idx;
                        cnt_q[q]  <= cnt_q[q] + CW'(1);
                    end
                    2'b01: begin
                        if (cnt_q[q] != '0) begin
                            head_q[q] <= link_next;
                            cnt_q[q]  <= cnt_q[q] - CW'(1);
                        end
                    end
                    2'b11: begin
                        tail_q[q] <= push_idx;
                        if (cnt_q[q] == CW'(1)) begin
                            head_q[q] <= push_idx;
                        end else if (cnt_q[q] != '0) begin
                            head_q[q] <= link_next;
                        end
                    end
                    default: ;
                endcase
            end
        end

        assign q_nonempty[q] = (cnt_q[q] != '0);
    end

    // bus-side output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_valid    <= 1'b0;
            pop_addr     <= '0;
            bad_push_err <= 1'b0;
        end else begin
            unique case (op)
                OP_POP, OP_BOTH: begin
                    pop_valid <= 1'b1;
                    pop_addr  <= pop_has ? pop_src_addr : '0;
                end
                default: begin
                    pop_valid <= 1'b0;
                    pop_addr  <= '0;
                end
            endcase
            if (push_en && !xl_ok) begin
                bad_push_err <= 1'b1;
            end
        end
    end

    assign peek_count = cnt_q[peek_q];
    assign peek_addr  = (cnt_q[peek_q] != '0) ? peek_head_addr : '0;
    assign irq        = q_nonempty & IRQ_MASK;
endmodule

// File: rtl/desc_qmgr_chk.sv
module desc_qmgr_chk #(
    parameter int NUM_Q    = 8,
    parameter int NUM_DESC = 32,
    parameter int AW       = 32,
    localparam int QW = $clog2(NUM_Q),
    localparam int CW = $clog2(NUM_DESC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_en,
    input logic [QW-1:0]    push_q,
    input logic             pop_en,
    input logic [QW-1:0]    pop_q,
    input logic             pop_valid,
    input logic [AW-1:0]    pop_addr,
    input logic [NUM_Q-1:0] q_nonempty,
    input logic             bad_push_err,
    input logic             push_ok,
    input logic [CW-1:0]    pop_cnt_cur
);
    p_pop_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> pop_valid);

    p_no_pop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_en |=> !pop_valid);

    p_pop_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_en && (pop_cnt_cur == '0) && !(push_ok && (push_q == pop_q)))
        |=> (pop_addr == '0));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_push_err |=> bad_push_err);

    p_drop_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !push_ok) |=> bad_push_err);

    p_same_q_returns_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_en && (push_q == pop_q)) |=> (pop_valid && (pop_addr != '0)));

    p_status_after_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !(pop_en && (pop_q == push_q))) |=> q_nonempty[$past(push_q)]);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_cnt_cur <= CW'(NUM_DESC));
endmodule

bind desc_qmgr desc_qmgr_chk #(
    .NUM_Q(NUM_Q), .NUM_DESC(NUM_DESC), .AW(AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_en      (push_en),
    .push_q       (push_q),
    .pop_en       (pop_en),
    .pop_q        (pop_q),
    .pop_valid    (pop_valid),
    .pop_addr     (pop_addr),
    .q_nonempty   (q_nonempty),
    .bad_push_err (bad_push_err),
    .push_ok      (push_ok),
    .pop_cnt_cur  (pop_cnt_cur)
);

// File: tb/desc_qmgr_tb.sv
`timescale 1ns/1ps
module desc_qmgr_tb;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_en;
    logic [2:0]  push_q;
    logic [31:0] push_addr;
    logic        pop_en;
    logic [2:0]  pop_q;
    logic        pop_valid;
    logic [31:0] pop_addr;
    logic [2:0]  peek_q;
    logic [31:0] peek_addr;
    logic [5:0]  peek_count;
    logic [7:0]  q_nonempty;
    logic [7:0]  irq;
    logic        bad_push_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS / 2) clk = ~clk;

    desc_qmgr u_dut (
        .clk(clk), .rst_n(rst_n),
        .push_en(push_en), .push_q(push_q), .push_addr(push_addr),
        .pop_en(pop_en), .pop_q(pop_q),
        .pop_valid(pop_valid), .pop_addr(pop_addr),
        .peek_q(peek_q), .peek_addr(peek_addr), .peek_count(peek_count),
        .q_nonempty(q_nonempty), .irq(irq), .bad_push_err(bad_push_err)
    );

    typedef struct packed {
        logic        pu;
        logic [2:0]  pq;
        logic [31:0] pa;
        logic        po;
        logic [2:0]  oq;
        logic [31:0] exp_addr;
        logic [5:0]  exp_cnt;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd1, 32'h1000, 1'b0, 3'd1, 32'h0,    6'd1}, // R3 build q1
        '{1'b1, 3'd1, 32'h8000, 1'b0, 3'd1, 32'h0,    6'd2}, // R3 R8 region 1 base
        '{1'b1, 3'd2, 32'h1040, 1'b0, 3'd2, 32'h0,    6'd1}, // R3 second queue
        '{1'b1, 3'd1, 32'h8780, 1'b0, 3'd1, 32'h0,    6'd3}, // R8 last of region 1
        '{1'b0, 3'd0, 32'h0,    1'b1, 3'd1, 32'h1000, 6'd2}, // R2 R3 first out
        '{1'b0, 3'd0, 32'h0,    1'b1, 3'd2, 32'h1040, 6'd0}, // R3 other queue intact
        '{1'b0, 3'd0, 32'h0,    1'b1, 3'd1, 32'h8000, 6'd1}, // R3 order
        '{1'b1, 3'd1, 32'h13C0, 1'b1, 3'd1, 32'h8780, 6'd1}, // R9 one entry, R8 last of region 0
        '{1'b0, 3'd0, 32'h0,    1'b1, 3'd1, 32'h13C0, 6'd0}, // R9 pushed became head
        '{1'b1, 3'd3, 32'h1000, 1'b1, 3'd3, 32'h1000, 6'd0}, // R9 empty queue push+pop
        '{1'b0, 3'd0, 32'h0,    1'b1, 3'd3, 32'h0,    6'd0}, // R5 pop empty
        '{1'b1, 3'd0, 32'h8080, 1'b0, 3'd0, 32'h0,    6'd1}  // R8 region 1 idx 17
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic cyc(input logic pu, input logic [2:0] pq, input logic [31:0] pa,
                       input logic po, input logic [2:0] oq);
        push_en = pu; push_q = pq; push_addr = pa;
        pop_en  = po; pop_q  = oq; peek_q   = oq;
        @(negedge clk);
        push_en = 1'b0; pop_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; push_en = 1'b0; pop_en = 1'b0;
        push_q = '0; pop_q = '0; peek_q = '0; push_addr = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 q_nonempty", 32'(q_nonempty), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 err", 32'(bad_push_err), 32'h0);
        chk("R1 pop_valid", 32'(pop_valid), 32'h0);
        chk("R1 pop_addr", pop_addr, 32'h0);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].pu, VEC[i].pq, VEC[i].pa, VEC[i].po, VEC[i].oq);
            if (VEC[i].po) begin
                chk($sformatf("R2 vec%0d pop_valid", i), 32'(pop_valid), 32'h1);
                chk($sformatf("R2 vec%0d pop_addr", i), pop_addr, VEC[i].exp_addr);
            end
            chk($sformatf("R3 vec%0d count", i), 32'(peek_count), 32'(VEC[i].exp_cnt));
        end
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 3'd0);
        chk("R8 idx17 round trip", pop_addr, 32'h8080);
        chk("R1 err still clear", 32'(bad_push_err), 32'h0);

        // R4 peek is non-destructive; R10 R11 status and interrupt
        cyc(1'b1, 3'd4, 32'h1000, 1'b0, 3'd4);
        cyc(1'b1, 3'd4, 32'h8000, 1'b0, 3'd4);
        cyc(1'b1, 3'd2, 32'h1040, 1'b0, 3'd4);
        chk("R4 peek addr", peek_addr, 32'h1000);
        chk("R4 peek count", 32'(peek_count), 32'd2);
        cyc(1'b0, 3'd0, 32'h0, 1'b0, 3'd4);
        chk("R4 peek again addr", peek_addr, 32'h1000);
        chk("R4 peek again count", 32'(peek_count), 32'd2);
        chk("R10 status", 32'(q_nonempty), 32'h14);
        chk("R11 irq subset", 32'(irq), 32'h10);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 3'd4);
        chk("R4 pop after peek", pop_addr, 32'h1000);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 3'd4);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 3'd2);
        chk("R10 status cleared", 32'(q_nonempty), 32'h0);
        chk("R11 irq cleared", 32'(irq), 32'h0);
        chk("R4 peek empty addr", peek_addr, 32'h0);

        // R7 misaligned push dropped
        cyc(1'b1, 3'd6, 32'h1020, 1'b0, 3'd6);
        chk("R7 err set", 32'(bad_push_err), 32'h1);
        chk("R7 queue unchanged", 32'(peek_count), 32'd0);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 3'd6);
        chk("R7 pop nothing", pop_addr, 32'h0);

        // R6 out of range, after a fresh reset
        do_reset();
        chk("R1 err cleared by reset", 32'(bad_push_err), 32'h0);
        cyc(1'b1, 3'd5, 32'h1400, 1'b0, 3'd5);
        chk("R8 past region 0 err", 32'(bad_push_err), 32'h1);
        chk("R6 queue unchanged", 32'(peek_count), 32'd0);
        chk("R6 irq not raised", 32'(irq), 32'h0);
        cyc(1'b1, 3'd5, 32'h8800, 1'b0, 3'd5);
        chk("R8 past region 1 dropped", 32'(peek_count), 32'd0);
        cyc(1'b1, 3'd5, 32'h0000_0000, 1'b0, 3'd5);
        chk("R6 zero dropped", 32'(peek_count), 32'd0);
        cyc(1'b1, 3'd5, 32'h8000, 1'b0, 3'd5);
        chk("R6 err sticky", 32'(bad_push_err), 32'h1);
        chk("R11 irq q5", 32'(irq), 32'h20);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 3'd5);
        chk("R2 pop after error", pop_addr, 32'h8000);
        cyc(1'b0, 3'd0, 32'h0, 1'b1, 3'd5);
        chk("R5 pop empty zero", pop_addr, 32'h0);
        chk("R5 stays empty", 32'(peek_count), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule